// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software reaches through a small register bus. A 32-bit magic value written to the control register arms it. Once armed, a down-counter loads from a 12-bit preload field scaled up by a fixed shift, and it counts down by one on every tick enable. Software keeps the system alive by writing two key words in sequence to the key register. That service is accepted only while the open window is active. With the half-window setting, the window covers the final half of the period. With any other setting, the whole period is open.

Two events are faults: a completed service sequence while the window is closed, and a tick that arrives while the counter already reads zero. A fault is sticky. It freezes the counter and sets a status bit. It also drives one of two level outputs, the interrupt request or the reset request, chosen by the reaction setting at the moment of the fault. Software cannot stop the watchdog after arming. Only the hardware reset clears the armed state and the fault.

Top module: `wwd_top`

## Requirements
- R1: After reset, both request outputs are low, every register reads zero except reaction (0x5) and window (0x05), and the counter reads zero.
- R2: The watchdog arms only when the 32-bit value 0xA98559DA is written to offset 0x90. Any other value leaves it disarmed, with the counter still and no fault. Offset 0x90 reads 1 in bit 0 once armed. Arming loads the counter.
- R3: Offset 0x94 holds a 12-bit preload. Writes keep bits 11:0. Every counter load takes the value preload shifted left by 13 bits.
- R4: While armed and not faulted, each clock with tick_i high lowers the counter by one. Offset 0xA0 reads the counter value.
- R5: A tick that arrives while the counter reads zero is a fault.
- R6: Writing 0x0000E51A and then 0x0000A35C to offset 0x9C, while the window is open, reloads the counter and raises no fault.
- R7: A key write that is not the expected next word returns the sequence to idle, with no reload and no fault. The word 0x0000A35C on its own does nothing.
- R8: Writing 0x50 to offset 0xA8 opens the window only while the counter is below half the load value. Any other window value keeps the whole period open. A completed sequence while the window is closed is a fault.
- R9: A fault sets bit 1 of offset 0x98. Both the fault and the frozen counter hold until reset.
- R10: Reaction value 0xA at offset 0xA4 sends a fault to irq_o. Any other value sends it to rst_req_o. The route is latched when the fault occurs, and the output stays high until reset.
- R11: Once armed, no write to offset 0x90 disarms the watchdog, reloads it or clears a fault. The hardware reset clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one decrement per high clock |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Fault routed to interrupt, level |
| rst_req_o | output | 1 | Fault routed to reset, level |

## Verification
The assertions assume three things about the inputs. rst_n is low at the start. The inputs carry known values and change only away from the rising edge. A write strobe lasts one cycle per intended write. The bench drives every input on falling edges and holds tick_i low while it writes registers, so the number of decrements is exactly the number of high-tick cycles it requests. Reads are combinational, so the bench samples rdata_o shortly after a falling edge, with no write in flight.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h90;
  localparam logic [7:0] OFS_PRE   = 8'h94;
  localparam logic [7:0] OFS_STAT  = 8'h98;
  localparam logic [7:0] OFS_KEY   = 8'h9C;
  localparam logic [7:0] OFS_CNT   = 8'hA0;
  localparam logic [7:0] OFS_REACT = 8'hA4;
  localparam logic [7:0] OFS_WIN   = 8'hA8;

  localparam logic [BUS_W-1:0] ARM_MAGIC = 32'hA98559DA;
  localparam logic [BUS_W-1:0] SVC_WORD1 = 32'h0000E51A;
  localparam logic [BUS_W-1:0] SVC_WORD2 = 32'h0000A35C;

  localparam logic [3:0] REACT_IRQ   = 4'hA;
  localparam logic [3:0] REACT_RESET = 4'h5;
  localparam logic [7:0] WIN_HALF    = 8'h50;
  localparam logic [7:0] WIN_RESET   = 8'h05;

  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_state_e;
endpackage

// File: rtl/wwd_regfile.sv
module wwd_regfile
  import wwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PRELOAD_W = 12,
  parameter int unsigned CNT_W     = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic                 armed_i,
  input  logic                 fault_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [PRELOAD_W-1:0] preload_o,
  output logic [3:0]           react_o,
  output logic [7:0]           win_o,
  output logic                 arm_req_o,
  output logic                 key_wr_o,
  output logic [BUS_W-1:0]     rdata_o
);
  logic hit_ctrl, hit_pre, hit_stat, hit_key, hit_cnt, hit_react, hit_win;

  assign hit_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_pre   = (addr_i == ADDR_W'(OFS_PRE));
  assign hit_stat  = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_key   = (addr_i == ADDR_W'(OFS_KEY));
  assign hit_cnt   = (addr_i == ADDR_W'(OFS_CNT));
  assign hit_react = (addr_i == ADDR_W'(OFS_REACT));
  assign hit_win   = (addr_i == ADDR_W'(OFS_WIN));

  assign arm_req_o = wr_en_i && hit_ctrl && (wdata_i == ARM_MAGIC);
  assign key_wr_o  = wr_en_i && hit_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_o <= '0;
      react_o   <= REACT_RESET;
      win_o     <= WIN_RESET;
    end else if (wr_en_i) begin
      if (hit_pre)   preload_o <= wdata_i[PRELOAD_W-1:0];
      if (hit_react) react_o   <= wdata_i[3:0];
      if (hit_win)   win_o     <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)  rdata_o[0]           = armed_i;
    if (hit_pre)   rdata_o[PRELOAD_W-1:0] = preload_o;
    if (hit_stat)  rdata_o[1]           = fault_i;
    if (hit_cnt)   rdata_o[CNT_W-1:0]   = cnt_i;
    if (hit_react) rdata_o[3:0]         = react_o;
    if (hit_win)   rdata_o[7:0]         = win_o;
  end

  a_r3_preload_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit_pre) |=> preload_o == $past(wdata_i[PRELOAD_W-1:0]));
endmodule

// File: rtl/wwd_keyseq.sv
module wwd_keyseq
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             seq_done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    seq_done_o = 1'b0;
    if (key_wr_i) begin
      if (state_q == SEQ_IDLE) begin
        state_d = (wdata_i == SVC_WORD1) ? SEQ_ARMED : SEQ_IDLE;
      end else begin
        state_d    = SEQ_IDLE;
        seq_done_o = (wdata_i == SVC_WORD2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R7: a mismatching word in the armed state returns to idle
  a_r7_mismatch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_i && state_q == SEQ_ARMED && wdata_i != SVC_WORD2) |=> state_q == SEQ_IDLE);
  a_r6_done_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (state_q == SEQ_ARMED && key_wr_i));
endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
#(
  parameter int unsigned PRELOAD_W = 12,
  parameter int unsigned SHIFT     = 13,
  parameter int unsigned CNT_W     = PRELOAD_W + SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 arm_req_i,
  input  logic                 seq_done_i,
  input  logic [PRELOAD_W-1:0] preload_i,
  input  logic [3:0]           react_i,
  input  logic [7:0]           win_i,
  output logic                 armed_o,
  output logic                 fault_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 irq_o,
  output logic                 rst_req_o
);
  function automatic logic [CNT_W-1:0] load_of(input logic [PRELOAD_W-1:0] p);
    return {p, {SHIFT{1'b0}}};
  endfunction

  function automatic logic window_open(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] ld,
                                       input logic half);
    return !half || (c < (ld >> 1));
  endfunction

  logic             armed_q, fault_q, irq_q, rst_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             live;
  logic             win_now;
  logic             evt_arm, evt_reload, evt_early, evt_expire, evt_fault, evt_dec;

  assign load_val   = load_of(preload_i);
  assign live       = armed_q && !fault_q;
  assign win_now    = window_open(cnt_q, load_val, win_i == WIN_HALF);
  assign evt_arm    = arm_req_i && !armed_q;
  assign evt_expire = live && tick_i && (cnt_q == '0);
  assign evt_early  = live && seq_done_i && !win_now;
  assign evt_reload = evt_arm || (live && seq_done_i && win_now);
  assign evt_fault  = evt_expire || evt_early;
  assign evt_dec    = live && tick_i && (cnt_q != '0) && !evt_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fault_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (evt_arm) armed_q <= 1'b1;
      if (evt_reload)   cnt_q <= load_val;
      else if (evt_dec) cnt_q <= cnt_q - 1'b1;
      if (evt_fault) begin
        fault_q <= 1'b1;
        if (react_i == REACT_IRQ) irq_q <= 1'b1;
        else                      rst_q <= 1'b1;
      end
    end
  end

  assign armed_o   = armed_q;
  assign fault_o   = fault_q;
  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  a_r4_one_down: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dec |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r5_expiry_faults: assert property (@(posedge clk) disable iff (!rst_n)
    evt_expire |=> fault_q);
  a_r6_service_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_reload && !evt_arm) |=> cnt_q == $past(load_val));
  a_r8_early_faults: assert property (@(posedge clk) disable iff (!rst_n)
    evt_early |=> fault_q);
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> $stable(cnt_q));
  a_r10_single_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, rst_q}));
  a_r10_route_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q || rst_q) |-> fault_q);
  a_r11_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  a_r2_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_req_i) |=> $stable(cnt_q) && !fault_q);
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PRELOAD_W = 12,
  parameter int unsigned SHIFT     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int unsigned CNT_W = PRELOAD_W + SHIFT;

  logic [PRELOAD_W-1:0] preload;
  logic [3:0]           react;
  logic [7:0]           win;
  logic                 arm_req, key_wr, seq_done, armed, fault;
  logic [CNT_W-1:0]     cnt;

  wwd_regfile #(.ADDR_W(ADDR_W), .PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .armed_i(armed), .fault_i(fault), .cnt_i(cnt),
    .preload_o(preload), .react_o(react), .win_o(win),
    .arm_req_o(arm_req), .key_wr_o(key_wr), .rdata_o(rdata_o)
  );

  wwd_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .key_wr_i(key_wr), .wdata_i(wdata_i), .seq_done_o(seq_done)
  );

  wwd_core #(.PRELOAD_W(PRELOAD_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .arm_req_i(arm_req), .seq_done_i(seq_done),
    .preload_i(preload), .react_i(react), .win_i(win),
    .armed_o(armed), .fault_o(fault), .cnt_o(cnt), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/test_wwd_top.sv
module test_wwd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = 32'h0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;
  int          checks = 0;
  int          errors = 0;

  localparam int SHIFT = 13;

  always #4 clk = ~clk;

  wwd_top i_wwd_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] scaled(input logic [11:0] p);
    return 32'(p) * (32'd1 << SHIFT);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic service();
    wr(8'h9C, 32'h0000E51A);
    wr(8'h9C, 32'h0000A35C);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    hw_reset();
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 rst_req", {31'b0, rst_req_o}, 0);
    rd(8'h90, d); check("R1 ctrl", d, 0);
    rd(8'h98, d); check("R1 status", d, 0);
    rd(8'hA0, d); check("R1 counter", d, 0);
    rd(8'hA4, d); check("R1 reaction", d, 32'h5);
    rd(8'hA8, d); check("R1 window", d, 32'h05);
  endtask

  task automatic t_arm_and_count();
    logic [31:0] d;
    hw_reset();
    wr(8'h94, 32'h0000_1FFF);
    rd(8'h94, d); check("R3 preload keeps 12 bits", d, 32'hFFF);
    wr(8'h94, 32'h1);
    wr(8'h90, 32'hA98559DB);
    ticks(5);
    rd(8'h90, d); check("R2 wrong magic not armed", d, 0);
    rd(8'hA0, d); check("R2 counter still", d, 0);
    rd(8'h98, d); check("R2 no fault", d, 0);
    wr(8'h90, 32'hA98559DA);
    rd(8'h90, d); check("R2 armed", d, 1);
    rd(8'hA0, d); check("R3 load on arm", d, scaled(12'h1));
    ticks(100);
    rd(8'hA0, d); check("R4 decrement", d, scaled(12'h1) - 100);
    wr(8'h90, 32'h0);
    wr(8'h90, 32'hA98559DA);
    rd(8'h90, d); check("R11 still armed", d, 1);
    rd(8'hA0, d); check("R11 no reload", d, scaled(12'h1) - 100);
    service();
    rd(8'hA0, d); check("R6 service reload", d, scaled(12'h1));
    rd(8'h98, d); check("R6 no fault", d, 0);
    ticks(50);
    wr(8'h9C, 32'h0000E51A);
    wr(8'h9C, 32'h00001234);
    wr(8'h9C, 32'h0000A35C);
    rd(8'hA0, d); check("R7 broken sequence no reload", d, scaled(12'h1) - 50);
    wr(8'h9C, 32'h0000A35C);
    rd(8'hA0, d); check("R7 lone second word", d, scaled(12'h1) - 50);
    rd(8'h98, d); check("R7 no fault", d, 0);
    service();
    rd(8'hA0, d); check("R7 restart works", d, scaled(12'h1));
  endtask

  task automatic t_early_service();
    logic [31:0] d;
    hw_reset();
    wr(8'h94, 32'h1);
    wr(8'hA8, 32'h50);
    wr(8'h90, 32'hA98559DA);
    ticks(1000);
    service();
    rd(8'h98, d); check("R8 early service faults", d, 32'h2);
    check("R10 default route reset", {30'b0, irq_o, rst_req_o}, 32'h1);
    ticks(10);
    rd(8'hA0, d); check("R9 counter frozen", d, scaled(12'h1) - 1000);
    wr(8'h90, 32'hA98559DA);
    wr(8'h90, 32'h0);
    rd(8'h98, d); check("R11 fault not cleared", d, 32'h2);
    hw_reset();
    rd(8'h98, d); check("R11 reset clears fault", d, 0);
    rd(8'h90, d); check("R11 reset disarms", d, 0);
    check("R11 outputs low", {30'b0, irq_o, rst_req_o}, 0);
  endtask

  task automatic t_window_and_expiry();
    logic [31:0] d;
    hw_reset();
    wr(8'h94, 32'h1);
    wr(8'hA4, 32'hA);
    wr(8'hA8, 32'h50);
    wr(8'h90, 32'hA98559DA);
    ticks(5000);
    service();
    rd(8'h98, d); check("R8 service in open window", d, 0);
    rd(8'hA0, d); check("R8 reload in window", d, scaled(12'h1));
    ticks(scaled(12'h1));
    rd(8'hA0, d); check("R5 counter at zero", d, 0);
    rd(8'h98, d); check("R5 zero not yet fault", d, 0);
    ticks(1);
    rd(8'h98, d); check("R5 expiry fault", d, 32'h2);
    check("R10 irq route", {30'b0, irq_o, rst_req_o}, 32'h2);
    wr(8'hA4, 32'h5);
    ticks(3);
    check("R10 route latched", {30'b0, irq_o, rst_req_o}, 32'h2);
  endtask

  task automatic t_boundaries();
    logic [31:0] d;
    hw_reset();
    wr(8'h94, 32'hFFF);
    wr(8'h90, 32'hA98559DA);
    rd(8'hA0, d); check("R3 max preload", d, scaled(12'hFFF));
    hw_reset();
    wr(8'h90, 32'hA98559DA);
    rd(8'hA0, d); check("R5 zero preload loads zero", d, 0);
    ticks(1);
    rd(8'h98, d); check("R5 zero preload faults", d, 32'h2);
    check("R10 reset route", {30'b0, irq_o, rst_req_o}, 32'h1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_arm_and_count();
    t_early_service();
    t_window_and_expiry();
    t_boundaries();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule